// File: doc/BRIEF.md
# Decimal Leading-Digit Angle Truncator

This combinational block sits in each stage of a decimal rotation pipeline. It takes the residual angle as six fractional decimal digits, each coded in excess-3 (a digit of value v carries the code v+3), and locates the most significant digit that is not zero. That digit is returned as a plain 4-bit decimal mantissa, and its place is returned as a 3-bit exponent. The stage uses the pair to address its arctangent and scale-compensation tables and to choose the digit shift applied to the coordinates.

The block also returns the residual cut off after that leading digit, still in excess-3. Every digit to its right is replaced by an excess-3 zero. When all six digits are zero, a flag is raised and the mantissa is forced to 0, so the downstream stage adds nothing and leaves its coordinates unchanged.

Top module: `lead_digit_trunc`

## Requirements
- R1: `mant_o` equals the decimal value (code minus 3) of the leftmost digit whose excess-3 code is not 0011. Digit 0, the tenths, occupies input bits [23:20], and each lower digit sits in the next lower 4-bit group.
- R2: `expo_o` gives the position of that digit: 0 for the tenths, rising by one per digit to 5 for the millionths.
- R3: Changing any digit to the right of the leading nonzero digit has no effect on `mant_o`, `expo_o` or `zero_o`.
- R4: `trunc_xs3_o` repeats the leading nonzero digit's code in its own field and holds 0011 in every other field. A single-nonzero-digit input therefore passes through unchanged.
- R5: When every input digit is 0011, `zero_o` is 1, `mant_o` is 0, `expo_o` is 6 (binary 110), and `trunc_xs3_o` is all 0011 digits. Otherwise `zero_o` is 0.
- R6: Only the code 0011 is taken as zero. A digit of excess-3 value 0 sitting to the left of a nonzero digit never becomes the leading digit, whatever its position.
- R7: The outputs follow the input with no clock or storage. A new input is reflected within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| resid_xs3_i | input | 24 | Residual angle, six excess-3 fractional digits, tenths in the top nibble |
| trunc_xs3_o | output | 24 | Residual truncated after its leading nonzero digit, excess-3 |
| mant_o | output | 4 | Leading nonzero digit, plain decimal 0 to 9 |
| expo_o | output | 3 | Position of the leading digit, 0 to 5, or 6 when all digits are zero |
| zero_o | output | 1 | High when every digit is zero |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the input and the outputs. The driver applies each residual on the falling clock edge and pushes the expected mantissa, exponent, flag and truncated value into a queue. The monitor pops and compares them on the next rising edge, half a cycle later, so the combinational paths have settled and no result depends on the order in which processes run at an edge.

// File: rtl/ldt_pkg.sv
package ldt_pkg;
    parameter int NUM_DIGITS = 6;
    parameter int DIGIT_W    = 4;
    localparam int RESID_W   = NUM_DIGITS * DIGIT_W;
    localparam int EXP_W     = $clog2(NUM_DIGITS + 1);
    localparam logic [DIGIT_W-1:0] XS3_ZERO = DIGIT_W'(3);
    localparam logic [DIGIT_W-1:0] XS3_BIAS = DIGIT_W'(3);

    typedef struct packed {
        logic [RESID_W-1:0] trunc;
        logic [DIGIT_W-1:0] mant;
        logic [EXP_W-1:0]   expo;
        logic               zero;
    } lead_t;
endpackage

// File: rtl/ldt_digit_class.sv
module ldt_digit_class
    import ldt_pkg::*;
(
    input  logic [DIGIT_W-1:0] code_i,
    output logic               nonzero_o,
    output logic [DIGIT_W-1:0] value_o
);
    always_comb begin
        nonzero_o = (code_i != XS3_ZERO);
        value_o   = code_i - XS3_BIAS;
    end

    // R6: a digit flagged as zero must carry value 0
    always_comb begin
        if (!nonzero_o) begin
            assert_zero_value_R6: assert (value_o == '0)
                else $error("digit flagged zero with nonzero value");
        end
    end
endmodule

// File: rtl/ldt_lead_scan.sv
module ldt_lead_scan #(
    parameter int N  = 6,
    parameter int EW = 3
) (
    input  logic [N-1:0]  nz_i,
    output logic [EW-1:0] pos_o,
    output logic          none_o
);
    typedef struct packed {
        logic [EW-1:0] pos;
        logic          none;
    } scan_t;

    scan_t scan_d;

    // priority from the tenths (index 0) downwards
    always_comb begin
        scan_d.pos  = EW'(N);
        scan_d.none = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (nz_i[i]) begin
                scan_d.pos  = EW'(i);
                scan_d.none = 1'b0;
            end
        end
    end

    assign pos_o  = scan_d.pos;
    assign none_o = scan_d.none;

    always_comb begin
        if (!none_o) begin
            assert_pos_hits_nonzero_R1: assert (nz_i[pos_o])
                else $error("selected position holds a zero digit");
            for (int j = 0; j < N; j++) begin
                if (j < int'(pos_o)) begin
                    assert_no_earlier_digit_R6: assert (!nz_i[j])
                        else $error("a more significant nonzero digit was skipped");
                end
            end
        end
    end
endmodule

// File: rtl/lead_digit_trunc.sv
module lead_digit_trunc
    import ldt_pkg::*;
(
    input  logic [RESID_W-1:0] resid_xs3_i,
    output logic [RESID_W-1:0] trunc_xs3_o,
    output logic [DIGIT_W-1:0] mant_o,
    output logic [EXP_W-1:0]   expo_o,
    output logic               zero_o
);
    logic [NUM_DIGITS-1:0] digit_nz;
    logic [DIGIT_W-1:0]    digit_val [NUM_DIGITS];
    logic [DIGIT_W-1:0]    digit_code[NUM_DIGITS];
    logic [EXP_W-1:0]      lead_pos;
    logic                  lead_none;
    lead_t                 res_d;

    // digit i = 0 is the tenths, held in the top nibble
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        assign digit_code[g] = resid_xs3_i[(NUM_DIGITS-1-g)*DIGIT_W +: DIGIT_W];
        ldt_digit_class u_class (
            .code_i    (digit_code[g]),
            .nonzero_o (digit_nz[g]),
            .value_o   (digit_val[g])
        );
    end

    ldt_lead_scan #(
        .N  (NUM_DIGITS),
        .EW (EXP_W)
    ) u_scan (
        .nz_i   (digit_nz),
        .pos_o  (lead_pos),
        .none_o (lead_none)
    );

    always_comb begin
        res_d.expo = lead_pos;
        res_d.zero = lead_none;
        res_d.mant = '0;
        res_d.trunc = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (!lead_none && (int'(lead_pos) == i)) begin
                res_d.mant = digit_val[i];
                res_d.trunc[(NUM_DIGITS-1-i)*DIGIT_W +: DIGIT_W] = digit_code[i];
            end else begin
                res_d.trunc[(NUM_DIGITS-1-i)*DIGIT_W +: DIGIT_W] = XS3_ZERO;
            end
        end
    end

    assign trunc_xs3_o = res_d.trunc;
    assign mant_o      = res_d.mant;
    assign expo_o      = res_d.expo;
    assign zero_o      = res_d.zero;

    logic [NUM_DIGITS-1:0] trunc_nz;
    always_comb begin
        for (int i = 0; i < NUM_DIGITS; i++) begin
            trunc_nz[i] = trunc_xs3_o[(NUM_DIGITS-1-i)*DIGIT_W +: DIGIT_W] != XS3_ZERO;
        end
    end

    always_comb begin
        assert_exp_range_R2: assert (int'(expo_o) <= NUM_DIGITS)
            else $error("exponent out of range");
        assert_trunc_single_R4: assert ($onehot0(trunc_nz))
            else $error("truncated value keeps more than one digit");
        if (zero_o) begin
            assert_zero_fields_R5: assert (mant_o == '0 && int'(expo_o) == NUM_DIGITS && trunc_nz == '0)
                else $error("all-zero input with non-identity fields");
        end else begin
            assert_mant_nonzero_R1: assert (mant_o != '0 && $countones(trunc_nz) == 1)
                else $error("nonzero input gave a zero mantissa");
        end
    end
endmodule

// File: tb/lead_digit_trunc_tb_top.sv
module lead_digit_trunc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] resid;
    logic [23:0] trunc;
    logic [3:0]  mant;
    logic [2:0]  expo;
    logic        zero;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [23:0] trunc;
        logic [3:0]  mant;
        logic [2:0]  expo;
        logic        zero;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    lead_digit_trunc dut_i (
        .resid_xs3_i (resid),
        .trunc_xs3_o (trunc),
        .mant_o      (mant),
        .expo_o      (expo),
        .zero_o      (zero)
    );

    task automatic check(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // drive six decimal digits (tenths first) and queue the expectation
    task automatic drive(input int d0, d1, d2, d3, d4, d5, input string tag);
        int d[6];
        exp_t e;
        logic [23:0] v;
        d = '{d0, d1, d2, d3, d4, d5};
        e.zero = 1'b1; e.mant = 4'd0; e.expo = 3'd6;
        for (int i = 0; i < 6; i++) begin
            v[(5-i)*4 +: 4] = 4'(d[i] + 3);
            if (e.zero && d[i] != 0) begin
                e.zero = 1'b0; e.mant = 4'(d[i]); e.expo = 3'(i);
            end
        end
        for (int i = 0; i < 6; i++)
            e.trunc[(5-i)*4 +: 4] = (!e.zero && int'(e.expo) == i) ? 4'(d[i] + 3) : 4'd3;
        e.tag = tag;
        @(negedge clk);
        resid = v;
        sb_q.push_back(e);
    endtask

    // monitor: results are due in the same cycle, sampled half a cycle later
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "mant", int'(mant), int'(e.mant));
            check(e.tag, "expo", int'(expo), int'(e.expo));
            check(e.tag, "zero", int'(zero), int'(e.zero));
            check(e.tag, "trunc", int'(trunc), int'(e.trunc));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual %0d expected %0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        resid = 24'h333333;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: all-zero residual, R5 and R7
        drive(0,0,0,0,0,0, "R5_reset_zero");
        drive(1,7,4,6,7,2, "R1_R2_tenths");
        drive(0,0,5,1,1,7, "R1_R2_thousandths");
        drive(0,0,0,1,1,7, "R2_ten_thousandths");
        drive(7,8,5,3,9,8, "R1_seven");
        drive(0,0,0,0,0,7, "R2_last_digit");
        drive(0,0,0,0,0,0, "R5_zero_again");
        // R3: lower digits changed, leading fields unchanged
        drive(0,3,0,0,0,0, "R3_low_clear");
        drive(0,3,9,9,9,9, "R3_low_full");
        drive(0,3,1,2,3,4, "R3_low_mixed");
        // R4: single nonzero digit passes unchanged
        drive(0,0,0,9,0,0, "R4_single");
        // R6: zeros ahead of a nonzero digit never lead
        drive(0,0,0,0,2,9, "R6_zeros_ahead");
        // every digit value at every position, R1 R2 R7 back to back
        for (int p = 0; p < 6; p++) begin
            for (int v = 1; v <= 9; v++) begin
                int d[6];
                d = '{0,0,0,0,0,0};
                d[p] = v;
                if (p < 5) d[5] = 9 - v + 1;
                drive(d[0], d[1], d[2], d[3], d[4], d[5], "R1_R2_R7_sweep");
            end
        end
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule